// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block takes an asynchronous trigger pin and turns it into a clean signal in a timer's clock domain. The pin first passes through a synchronizer. An optional inversion then chooses which level and edge count as active. An optional edge prescaler slows the active-edge rate. Finally a sampled digital glitch filter removes short disturbances before the result reaches the timer.

The block has three outputs. The first is the filtered level. The second is a single-cycle pulse on each active (rising) edge of that level. The third is a counter-increment strobe, which fires on the same pulse only when external clocking is switched on. All configuration comes in as plain field inputs whose owning register resets to zero. The zero setting means no inversion, no prescaling, no filtering and no external clocking.

The sample rate and the required run length of the filter are both chosen by one 4-bit code. The sample clock equals the internal clock divided by 1, 2, 4, 8, 16 or 32.

Top module: `ext_trig_conditioner`

## Requirements
- R1: After reset, trig_level, trig_edge and cnt_strobe are all 0.
- R2: With all configuration at 0, a rising pin is registered at 4 clock edges, two synchronizer stages plus the prescaler stage plus the filter stage. trig_level then goes to 1 and trig_edge pulses high for exactly one cycle, in the first cycle trig_level is 1.
- R3: cfg_invert = 1 inverts the synchronized pin. A low pin then gives trig_level = 1, and a falling pin edge gives a trig_edge pulse.
- R4: cfg_psc values 0, 1, 2 and 3 divide the active-edge rate by 1, 2, 4 and 8. For a code k > 0, the divided signal toggles once every 2^(k-1) active input edges. So after P input edges from a cleared counter there are floor((P + 2^(k-1)) / 2^k) divided active edges.
- R5: Any change of cfg_psc clears the prescaler's edge count.
- R6: Filter codes 1, 2 and 3 sample every cycle and need 2, 4 and 8 matching samples. A high run shorter than that count is discarded.
- R7: Filter codes 4/5, 6/7 and 8/9 sample every 2, 4 and 8 cycles, with 6/8 matches. Codes 10/11/12 sample every 16 cycles with 5/6/8 matches. Codes 13/14/15 sample every 32 cycles with 5/6/8 matches. Code 0 samples every cycle and needs one match. Between sample points the filtered level never changes.
- R8: With cfg_extclk_en = 1, cnt_strobe pulses in the same cycle as every trig_edge pulse. With cfg_extclk_en = 0, cnt_strobe stays 0.
- R9: trig_level only takes a new value that equals the sample just taken, and only after the required run of consecutive differing samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| cfg_invert | input | 1 | 1 = low level / falling edge is active |
| cfg_psc | input | 2 | Edge prescaler code (divide by 2^code) |
| cfg_flt | input | 4 | Filter code: sample rate and match count |
| cfg_extclk_en | input | 1 | Enables the counter-increment strobe |
| trig_level | output | 1 | Filtered, conditioned trigger level |
| trig_edge | output | 1 | One-cycle pulse on each active edge of trig_level |
| cnt_strobe | output | 1 | Counter-increment strobe for external clocking |

## Verification
Two functions land in the same cycle: the edge pulse and the counter-increment strobe both come from one transition of the filtered level. In random runs the external-clock enable is drawn independently for each pulse. The bench counts strobes and edges in the same sampling slot, so every strobe must fall on an edge cycle, and the strobe total must equal the edge total when enabled and be zero when disabled. Filter codes and pulse lengths are drawn so that each pulse is clearly below or clearly above the acceptance length. That makes the expected edge count per pulse exact whatever the phase of the sample divider.

// File: rtl/etc_pkg.sv
package etc_pkg;

    localparam int DIV_W   = 5;   // sample divider reaches /32
    localparam int MATCH_W = 4;   // largest run length is 8

    // Sample-enable mask: a sample is taken when (divider & mask) == 0.
    function automatic logic [DIV_W-1:0] flt_div_mask(input logic [3:0] code);
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3: flt_div_mask = 5'd0;
            4'd4, 4'd5:             flt_div_mask = 5'd1;
            4'd6, 4'd7:             flt_div_mask = 5'd3;
            4'd8, 4'd9:             flt_div_mask = 5'd7;
            4'd10, 4'd11, 4'd12:    flt_div_mask = 5'd15;
            default:                flt_div_mask = 5'd31;
        endcase
    endfunction

    // Number of consecutive differing samples needed to move the output.
    function automatic logic [MATCH_W-1:0] flt_need(input logic [3:0] code);
        case (code)
            4'd0:                     flt_need = 4'd1;
            4'd1:                     flt_need = 4'd2;
            4'd2:                     flt_need = 4'd4;
            4'd10, 4'd13:             flt_need = 4'd5;
            4'd4, 4'd6, 4'd8,
            4'd11, 4'd14:             flt_need = 4'd6;
            default:                  flt_need = 4'd8;
        endcase
    endfunction

    typedef struct packed {
        logic       prev;
        logic [2:0] cnt;
        logic [1:0] code;
        logic       out;
    } psc_state_t;

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic [MATCH_W-1:0] match;
        logic               out;
    } flt_state_t;

endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/etc_prescale.sv
module etc_prescale
    import etc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_in,
    input  logic [1:0] code,
    output logic       lvl_out
);
    psc_state_t d, q;
    logic       rise;
    logic [3:0] last;

    always_comb begin
        d      = q;
        d.prev = lvl_in;
        d.code = code;
        rise   = lvl_in & ~q.prev;
        last   = (code == 2'd0) ? 4'd0 : (4'd1 << (code - 2'd1)) - 4'd1;
        if (code == 2'd0) begin
            d.out = lvl_in;
            d.cnt = '0;
        end else if (code != q.code) begin
            d.cnt = '0;
        end else if (rise) begin
            if ({1'b0, q.cnt} >= last) begin
                d.out = ~q.out;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_out = q.out;

    // divided output moves only on an input active edge
    p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 2'd0 && !rise) |=> $stable(lvl_out));
endmodule

// File: rtl/etc_filter.sv
module etc_filter
    import etc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_in,
    input  logic [3:0] code,
    output logic       lvl_out
);
    flt_state_t         d, q;
    logic [DIV_W-1:0]   mask;
    logic [MATCH_W-1:0] need;
    logic               smp_en;

    always_comb begin
        d      = q;
        d.div  = q.div + 1'b1;
        mask   = flt_div_mask(code);
        need   = flt_need(code);
        smp_en = ((q.div & mask) == '0);
        if (smp_en) begin
            if (smp_in == q.out) begin
                d.match = '0;
            end else if (q.match + 4'd1 >= need) begin
                d.out   = smp_in;
                d.match = '0;
            end else begin
                d.match = q.match + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_out = q.out;

    p_hold_between_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(lvl_out));

    p_new_level_is_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_out != $past(lvl_out)) |-> (lvl_out == $past(smp_in)));
endmodule

// File: rtl/ext_trig_conditioner.sv
module ext_trig_conditioner #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_pin,
    input  logic       cfg_invert,
    input  logic [1:0] cfg_psc,
    input  logic [3:0] cfg_flt,
    input  logic       cfg_extclk_en,
    output logic       trig_level,
    output logic       trig_edge,
    output logic       cnt_strobe
);
    logic pin_sync, pol_lvl, psc_lvl, flt_lvl;
    logic prev_d, prev_q;

    etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_pin), .sync_out(pin_sync));

    assign pol_lvl = pin_sync ^ cfg_invert;

    etc_prescale u_psc (
        .clk(clk), .rst_n(rst_n), .lvl_in(pol_lvl), .code(cfg_psc), .lvl_out(psc_lvl));

    etc_filter u_flt (
        .clk(clk), .rst_n(rst_n), .smp_in(psc_lvl), .code(cfg_flt), .lvl_out(flt_lvl));

    always_comb begin
        prev_d = flt_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign trig_level = flt_lvl;
    assign trig_edge  = flt_lvl & ~prev_q;
    assign cnt_strobe = trig_edge & cfg_extclk_en;

    p_edge_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |=> !trig_edge);

    p_edge_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |-> (trig_level && !$past(trig_level)));
endmodule

// File: tb/ext_trig_conditioner_test.sv
module ext_trig_conditioner_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_pin = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_psc = 2'd0;
    logic [3:0] cfg_flt = 4'd0;
    logic       cfg_extclk_en = 1'b0;
    logic       trig_level, trig_edge, cnt_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;
    int strobe_cnt = 0;

    always #5 clk = ~clk;

    ext_trig_conditioner uut (
        .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .cfg_invert(cfg_invert),
        .cfg_psc(cfg_psc), .cfg_flt(cfg_flt), .cfg_extclk_en(cfg_extclk_en),
        .trig_level(trig_level), .trig_edge(trig_edge), .cnt_strobe(cnt_strobe));

    // outputs are stable over the cycle before each rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (trig_edge)  edge_cnt++;
            if (cnt_strobe) strobe_cnt++;
        end
    end

    function automatic int n_of(input int c);
        int t[16] = '{1, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
        return t[c];
    endfunction

    function automatic int d_of(input int c);
        if (c < 4)  return 1;
        if (c < 6)  return 2;
        if (c < 8)  return 4;
        if (c < 10) return 8;
        if (c < 13) return 16;
        return 32;
    endfunction

    function automatic int psc_edges(input int p, input int k);
        if (k == 0) return p;
        return (p + (1 << (k - 1))) / (1 << k);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        cfg_invert = 0; cfg_psc = 0; cfg_flt = 0; cfg_extclk_en = 0; trig_pin = 0;
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    task automatic pulse(input int hi, input int lo);
        trig_pin = 1; tick(hi);
        trig_pin = 0; tick(lo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int e0, s0, r;
        r = $urandom(32'd4242);
        do_reset();
        // R1 reset state
        check("R1 level", trig_level, 0);
        check("R1 edge", trig_edge, 0);
        check("R1 strobe", cnt_strobe, 0);

        // R2 latency and one-cycle edge
        trig_pin = 1;
        tick(3);
        check("R2 level before 4th edge", trig_level, 0);
        tick(1);
        check("R2 level at 4th edge", trig_level, 1);
        check("R2 edge pulse", trig_edge, 1);
        tick(1);
        check("R2 edge width", trig_edge, 0);
        trig_pin = 0; tick(8);
        check("R2 level falls", trig_level, 0);

        // R3 polarity, filter code 3 masks the switch-over glitch
        do_reset();
        cfg_flt = 4'd3; cfg_invert = 1; trig_pin = 1;
        tick(20);
        e0 = edge_cnt;
        check("R3 high pin inactive", trig_level, 0);
        trig_pin = 0; tick(20);
        check("R3 low pin active", trig_level, 1);
        check("R3 falling pin edge", edge_cnt - e0, 1);
        trig_pin = 1; tick(20);
        check("R3 high pin returns inactive", trig_level, 0);

        // R4 prescaler divide ratios
        do_reset();
        for (int k = 0; k < 4; k++) begin
            cfg_psc = 2'(k); tick(4);
            e0 = edge_cnt;
            for (int i = 0; i < 16; i++) pulse(3, 3);
            tick(8);
            check($sformatf("R4 psc=%0d edges", k), edge_cnt - e0, psc_edges(16, k));
        end

        // R5 code write clears the edge count
        do_reset();
        cfg_psc = 2'd3; tick(4);
        e0 = edge_cnt;
        for (int i = 0; i < 3; i++) pulse(3, 3);
        cfg_psc = 2'd2; tick(3);
        cfg_psc = 2'd3; tick(3);
        for (int i = 0; i < 3; i++) pulse(3, 3);
        tick(8);
        check("R5 no edge after clear", edge_cnt - e0, 0);
        pulse(3, 3); tick(8);
        check("R5 edge at 4th edge after clear", edge_cnt - e0, 1);

        // R6 fast filter run lengths
        do_reset();
        cfg_flt = 4'd3; tick(2);
        e0 = edge_cnt;
        pulse(7, 30);
        check("R6 code3 run 7 rejected", edge_cnt - e0, 0);
        pulse(8, 30);
        check("R6 code3 run 8 accepted", edge_cnt - e0, 1);
        cfg_flt = 4'd2; tick(2);
        e0 = edge_cnt;
        pulse(3, 30);
        check("R6 code2 run 3 rejected", edge_cnt - e0, 0);
        pulse(4, 30);
        check("R6 code2 run 4 accepted", edge_cnt - e0, 1);

        // R7 divided sampling
        cfg_flt = 4'd10; tick(2);
        e0 = edge_cnt;
        pulse(64, 150);
        check("R7 code10 run 64 rejected", edge_cnt - e0, 0);
        pulse(80, 150);
        check("R7 code10 run 80 accepted", edge_cnt - e0, 1);
        cfg_flt = 4'd15; tick(2);
        e0 = edge_cnt;
        pulse(224, 330);
        check("R7 code15 run 224 rejected", edge_cnt - e0, 0);
        pulse(256, 330);
        check("R7 code15 run 256 accepted", edge_cnt - e0, 1);

        // R8 strobe gating, directed
        cfg_flt = 4'd0; cfg_extclk_en = 0; tick(2);
        e0 = edge_cnt; s0 = strobe_cnt;
        pulse(4, 10);
        check("R8 disabled edge seen", edge_cnt - e0, 1);
        check("R8 disabled no strobe", strobe_cnt - s0, 0);
        cfg_extclk_en = 1; tick(1);
        pulse(4, 10);
        check("R8 enabled strobe", strobe_cnt - s0, 1);

        // R6 R7 R8 R9 random pulses with random filter code and enable
        for (int it = 0; it < 30; it++) begin
            int c, dd, nn, acc, len, en;
            c   = int'($urandom % 16);
            dd  = d_of(c); nn = n_of(c);
            acc = int'($urandom % 2);
            if (c <= 1) acc = 1;
            if (acc == 1) len = nn * dd + int'($urandom % (dd + 1)) + ((c == 0) ? 1 : 0);
            else          len = (nn - 1) * dd - int'($urandom % dd);
            en  = int'($urandom % 2);
            cfg_flt = 4'(c); cfg_extclk_en = en[0];
            tick(2);
            e0 = edge_cnt; s0 = strobe_cnt;
            pulse(len, nn * dd + 2 * dd + 8);
            check($sformatf("R9 code=%0d len=%0d edges", c, len), edge_cnt - e0, acc);
            check($sformatf("R8 code=%0d en=%0d strobes", c, en), strobe_cnt - s0, acc * en);
            check("R9 level back low", trig_level, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule